// File: doc/BRIEF.md
# Byte Blit Engine with Logic Ops and Two-Colour Fill

The engine moves bytes from memory to memory. It has three modes. In copy mode it reads a source byte and can merge it with the byte already at the destination through a selectable logic operator. In solid mode it writes one constant byte over a region. In masked mode it reads mask bytes from the source and, for each mask bit, writes one of two constant bytes to the destination.

Software programs the engine through a small register write port, then writes the control word with the go bit set. The engine works one byte at a time on a synchronous memory port: read data returns in the cycle after the read strobe. A done pulse marks the end of a run.

Source reads can skip every other group of 1, 2 or 4 bytes. A per-step signed address offset, built from a forward register and a backward register, can be added to the source address, the destination address, or both.

Top module: `blit_engine`

## Requirements
- R1: After reset `busy`, `done`, `mem_rd` and `mem_wr` are all 0. The configuration registers are selected by `cfg_addr`: 0x00 control, 0x04 source address, 0x08 destination address, 0x0C byte count, 0x10 fill A (bits 7:0), 0x14 fill B (bits 7:0), 0x18 forward offset, 0x1C backward offset.
- R2: Control bit 0 is go. With bits 4 and 3 clear and operator bits 2:1 equal to 0, each destination byte receives the source byte. The run makes exactly one read per byte.
- R3: Operator codes 1, 2 and 3 give AND, OR and XOR of the source byte with the current destination byte. Each byte is read-modify-written, which makes two reads per byte.
- R4: Control bit 4 (solid) writes the low byte of fill A to every destination byte and makes no memory read.
- R5: When bits 4 and 3 are both set, solid mode wins.
- R6: With control bit 3 (masked), each source byte supplies 8 mask bits. A 1 bit writes fill B and a 0 bit writes fill A. With control bit 5 clear, bits are used most significant first.
- R7: With control bit 5 set, masked mode uses mask bits least significant first.
- R8: With control bit 6 set, source reads take G bytes and then skip G bytes. G is set by bits 8:7: 0 gives 1, 1 gives 2, 2 or 3 give 4. The skipping also applies to the mask bytes.
- R9: The offset registers keep only bits 21:4 of the written value. After each step, the address advances by 1 plus (forward minus backward). The offset term applies to the source address when bit 9 is set and to the destination address when bit 10 is set.
- R10: When the last byte is written, `done` pulses high for one cycle and `busy` falls in that same cycle. Go with a byte count of 0 gives the pulse in the next cycle and makes no memory access.
- R11: While busy, every configuration write is ignored, except a control write with bit 0 clear. That write stops the run at once, with no done pulse and no further memory access.
- R12: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| mem_addr | output | AW | Memory byte address |
| mem_rd | output | 1 | Memory read strobe, data returns next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Most internal faults show up in memory contents, in the end-of-run pulse, or in the read count.

- A wrong address step or group counter writes to a byte that should stay untouched, or reads the wrong source byte, within a few cycles of the first skip or offset step.
- A wrong mask bit index puts the two fill values in the wrong order within the first eight bytes.
- A wrong byte counter moves the done pulse or lengthens the run, which shows in the pulse width or in guard bytes.
- A wrong mode latch shows as extra or missing reads.

// File: rtl/blit_engine.sv
module blit_engine #(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [4:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          busy,
  output logic          done
);

  localparam logic [31:0] OFS_MASK = 32'h003F_FFF0;

  typedef enum logic [1:0] {S_IDLE, S_RSRC, S_LATCH, S_WRITE} st_t;

  st_t           st;
  logic [10:0]   ctrl;
  logic [AW-1:0] src, dst, fwd, bwd;
  logic [CW-1:0] cnt;
  logic [7:0]    fa, fb, dq;
  logic [2:0]    bitn;
  logic [1:0]    grp;

  wire solid  = ctrl[4];
  wire masked = ctrl[3] & ~ctrl[4];
  wire rmw    = ~ctrl[3] & ~ctrl[4] & (ctrl[2:1] != 2'd0);
  wire [2:0] gsz = (ctrl[8:7] == 2'd0) ? 3'd1 : (ctrl[8:7] == 2'd1) ? 3'd2 : 3'd4;
  wire glast  = ctrl[6] & ({1'b0, grp} == gsz - 3'd1);
  wire [AW-1:0] delta    = fwd - bwd;
  wire [AW-1:0] src_step = AW'(1) + (glast ? AW'(gsz) : '0) + (ctrl[9] ? delta : '0);
  wire [AW-1:0] dst_step = AW'(1) + (ctrl[10] ? delta : '0);
  wire mbit     = ctrl[5] ? dq[bitn] : dq[3'd7 - bitn];
  wire cfg_ctrl = cfg_we & (cfg_addr[4:2] == 3'd0);
  wire abort    = busy & cfg_ctrl & ~cfg_wdata[0];

  assign busy     = st != S_IDLE;
  assign mem_rd   = (st == S_RSRC) | ((st == S_LATCH) & rmw);
  assign mem_wr   = st == S_WRITE;
  assign mem_addr = (st == S_RSRC) ? src : dst;

  always_comb begin
    if (solid)       mem_wdata = fa;
    else if (masked) mem_wdata = mbit ? fb : fa;
    else begin
      case (ctrl[2:1])
        2'd1:    mem_wdata = dq & mem_rdata;
        2'd2:    mem_wdata = dq | mem_rdata;
        2'd3:    mem_wdata = dq ^ mem_rdata;
        default: mem_wdata = dq;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; done <= 1'b0; ctrl <= '0;
      src <= '0; dst <= '0; fwd <= '0; bwd <= '0; cnt <= '0;
      fa <= '0; fb <= '0; dq <= '0; bitn <= '0; grp <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        st <= S_IDLE;
      end else if (!busy) begin
        if (cfg_we) begin
          case (cfg_addr[4:2])
            3'd0: begin
              ctrl <= cfg_wdata[10:0];
              bitn <= '0;
              grp  <= '0;
              if (cfg_wdata[0]) begin
                if (cnt == '0) done <= 1'b1;
                else st <= cfg_wdata[4] ? S_WRITE : S_RSRC;
              end
            end
            3'd1: src <= cfg_wdata[AW-1:0];
            3'd2: dst <= cfg_wdata[AW-1:0];
            3'd3: cnt <= cfg_wdata[CW-1:0];
            3'd4: fa  <= cfg_wdata[7:0];
            3'd5: fb  <= cfg_wdata[7:0];
            3'd6: fwd <= AW'(cfg_wdata & OFS_MASK);
            default: bwd <= AW'(cfg_wdata & OFS_MASK);
          endcase
        end
      end else begin
        case (st)
          S_RSRC: begin
            src <= src + src_step;
            grp <= glast ? 2'd0 : grp + 2'd1;
            st  <= S_LATCH;
          end
          S_LATCH: begin
            dq <= mem_rdata;
            st <= S_WRITE;
          end
          S_WRITE: begin
            dst  <= dst + dst_step;
            cnt  <= cnt - CW'(1);
            bitn <= bitn + 3'd1;
            if (cnt == CW'(1)) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else if (solid || (masked && bitn != 3'd7)) st <= S_WRITE;
            else st <= S_RSRC;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_last_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && cnt == CW'(1) && !abort) |=> done);

  assert_solid_noread_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && solid) |-> !mem_rd);

  assert_rmw_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && rmw) |-> $past(mem_rd));

  assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !done && !mem_wr && !mem_rd));

endmodule

// File: tb/blit_engine_tb.sv
module blit_engine_tb_top;
  localparam int AW = 24;
  localparam logic [31:0] GO = 32'h1, MSK = 32'h8, SOL = 32'h10, LSB = 32'h20,
                          SKP = 32'h40, OSRC = 32'h200, ODST = 32'h400;
  // {op[1:0], src byte, dst byte, expected byte}
  localparam logic [25:0] VEC [6] = '{
    {2'd0, 8'hA5, 8'h3C, 8'hA5},
    {2'd1, 8'hF0, 8'h3C, 8'h30},
    {2'd2, 8'hF0, 8'h0C, 8'hFC},
    {2'd3, 8'hFF, 8'h0F, 8'hF0},
    {2'd3, 8'h55, 8'h55, 8'h00},
    {2'd1, 8'h0F, 8'hFF, 8'h0F}};

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [4:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_wr, busy, done;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] mem [0:4095];
  logic pk_en = 0;
  logic [11:0] pk_a = '0;
  logic [7:0] pk_d = '0;
  int rd_cnt = 0, wr_cnt = 0, done_cnt = 0, cyc = 0;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  blit_engine #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (pk_en) mem[pk_a] <= pk_d;
    else if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
    if (mem_rd) rd_cnt <= rd_cnt + 1;
    if (mem_wr) wr_cnt <= wr_cnt + 1;
    if (done) done_cnt <= done_cnt + 1;
  end

  always @(negedge clk) if (cyc > 150000) begin
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%0d exp<150000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic poke(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); pk_en = 1; pk_a = a; pk_d = d;
  endtask

  task automatic poke_end();
    @(negedge clk); pk_en = 0;
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] n);
    cfg(5'h04, s); cfg(5'h08, d); cfg(5'h0C, n);
  endtask

  task automatic run(input logic [31:0] c, input string req);
    int pl;
    pl = 0;
    cfg(5'h00, c);
    for (int i = 0; i < 3000; i++) begin
      if (done) pl++;
      else if (pl > 0) break;
      @(negedge clk);
    end
    chk(pl, 1, {req, " R10 done pulse width"});
    chk(busy, 0, {req, " R10 busy low after done"});
  endtask

  initial begin
    int r0;
    logic [7:0] m;
    repeat (3) @(negedge clk);
    chk({busy, done, mem_rd, mem_wr}, 0, "R1 reset state");
    rst_n = 1;
    @(negedge clk);
    chk({busy, done, mem_rd, mem_wr}, 0, "R1 idle after reset");

    // table walk: copy and logic operators
    foreach (VEC[k]) begin
      for (int i = 0; i < 4; i++) begin poke(12'h010 + 12'(i), VEC[k][23:16]); poke(12'h020 + 12'(i), VEC[k][15:8]); end
      poke(12'h024, 8'hEE); poke_end();
      setup(32'h010, 32'h020, 4);
      r0 = rd_cnt;
      run(GO | (32'(VEC[k][25:24]) << 1), "R2/R3 vector");
      for (int i = 0; i < 4; i++) chk(mem[12'h020 + 12'(i)], VEC[k][7:0], "R2/R3 op result");
      chk(mem[12'h024], 8'hEE, "R2/R3 guard byte");
      chk(rd_cnt - r0, (VEC[k][25:24] == 0) ? 4 : 8, "R2/R3 read count");
    end

    // R4 solid fill
    poke(12'h105, 8'h00); poke_end();
    cfg(5'h10, 32'h1234_5677);
    setup(0, 32'h100, 5);
    r0 = rd_cnt;
    run(GO | SOL, "R4");
    for (int i = 0; i < 5; i++) chk(mem[12'h100 + 12'(i)], 8'h77, "R4 solid byte");
    chk(mem[12'h105], 8'h00, "R4 guard byte");
    chk(rd_cnt - r0, 0, "R4 no reads");

    // R5 priority
    cfg(5'h10, 32'h33); cfg(5'h14, 32'h44);
    setup(32'h500, 32'h110, 4);
    r0 = rd_cnt;
    run(GO | SOL | MSK, "R5");
    for (int i = 0; i < 4; i++) chk(mem[12'h110 + 12'(i)], 8'h33, "R5 solid wins");
    chk(rd_cnt - r0, 0, "R5 no reads");

    // R6/R7 masked fill
    poke(12'h500, 8'hB2); poke(12'h501, 8'h0F); poke(12'h502, 8'hF0); poke_end();
    cfg(5'h10, 32'h11); cfg(5'h14, 32'h22);
    setup(32'h500, 32'h520, 10);
    run(GO | MSK, "R6");
    for (int j = 0; j < 10; j++) begin
      m = (j < 8) ? 8'hB2 : 8'h0F;
      chk(mem[12'h520 + 12'(j)], m[7 - (j % 8)] ? 8'h22 : 8'h11, "R6 MSb-first mask");
    end
    setup(32'h500, 32'h540, 10);
    run(GO | MSK | LSB, "R7");
    for (int j = 0; j < 10; j++) begin
      m = (j < 8) ? 8'hB2 : 8'h0F;
      chk(mem[12'h540 + 12'(j)], m[j % 8] ? 8'h22 : 8'h11, "R7 LSb-first mask");
    end
    setup(32'h500, 32'h560, 16);
    run(GO | MSK | SKP, "R8 mask");
    for (int j = 0; j < 16; j++) begin
      m = (j < 8) ? 8'hB2 : 8'hF0;
      chk(mem[12'h560 + 12'(j)], m[7 - (j % 8)] ? 8'h22 : 8'h11, "R8 skipped mask bytes");
    end

    // R8 copy skipping, group codes 0,1,2
    for (int i = 0; i < 16; i++) poke(12'h600 + 12'(i), 8'h80 + 8'(i));
    poke_end();
    for (int g = 0; g < 3; g++) begin
      int n;
      n = 1 << g;
      setup(32'h600, 32'h700 + 32'(g * 16), 6);
      run(GO | SKP | (32'(g) << 7), "R8 copy");
      for (int j = 0; j < 6; j++)
        chk(mem[12'h700 + 12'(g * 16 + j)], 8'h80 + 8'((j / n) * 2 * n + j % n), "R8 source skip");
    end

    // R9 destination offsets with masking of low bits
    poke(12'h901, 8'h00); poke(12'h910, 8'h00); poke(12'h920, 8'h00); poke_end();
    cfg(5'h18, 32'h2F); cfg(5'h1C, 32'h10); cfg(5'h10, 32'h6B);
    setup(0, 32'h900, 3);
    run(GO | SOL | ODST, "R9 dst");
    chk(mem[12'h900], 8'h6B, "R9 dst step 0");
    chk(mem[12'h911], 8'h6B, "R9 dst step 1");
    chk(mem[12'h922], 8'h6B, "R9 dst step 2");
    chk({mem[12'h901], mem[12'h910], mem[12'h920]}, 0, "R9 untouched bytes");

    // R9 source offsets, negative net step
    poke(12'hA30, 8'hC1); poke(12'hA21, 8'hC2); poke(12'hA12, 8'hC3); poke_end();
    cfg(5'h18, 32'h0); cfg(5'h1C, 32'h10);
    setup(32'hA30, 32'hB00, 3);
    run(GO | OSRC, "R9 src");
    chk({mem[12'hB00], mem[12'hB01], mem[12'hB02]}, 32'hC1C2C3, "R9 src backward step");

    // R10 zero length
    setup(0, 32'hB10, 0);
    r0 = wr_cnt + rd_cnt;
    run(GO | SOL, "R10 zero length");
    chk(wr_cnt + rd_cnt - r0, 0, "R10 zero length no access");

    // R11 writes while busy ignored
    poke(12'hD00, 8'h00); poke_end();
    cfg(5'h10, 32'h5A);
    setup(0, 32'hC00, 16);
    cfg(5'h00, GO | SOL);
    cfg(5'h10, 32'hA5);
    cfg(5'h08, 32'hD00);
    cfg(5'h00, GO | MSK);
    while (busy) @(negedge clk);
    for (int i = 0; i < 16; i++) chk(mem[12'hC00 + 12'(i)], 8'h5A, "R11 fill unchanged while busy");
    chk(mem[12'hD00], 8'h00, "R11 dst write ignored");

    // R11 abort
    poke(12'hE30, 8'h00); poke_end();
    cfg(5'h10, 32'h77);
    setup(0, 32'hE00, 64);
    r0 = done_cnt;
    cfg(5'h00, GO | SOL);
    repeat (4) @(negedge clk);
    cfg(5'h00, 32'h0);
    chk(busy, 0, "R11 abort clears busy");
    repeat (10) @(negedge clk);
    chk(done_cnt - r0, 0, "R11 abort no done");
    chk(mem[12'hE00], 8'h77, "R11 first byte written");
    chk(mem[12'hE30], 8'h00, "R11 later byte untouched");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule